// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage In-Order Pipeline

This block follows every instruction of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) and records whether that instruction has faulted, the cause, and its program counter. Any of the first four stages may raise a fault on the instruction it currently holds. The fault travels with the instruction, and nothing acts on it until the instruction reaches the end of the memory stage, which is the commit point. Because of this, faults that appear together in one cycle are resolved in program order: the instruction deepest in the pipe is the oldest, so its fault is taken first.

When a faulting instruction reaches commit, the block blocks its memory write and its register write. It kills the younger instructions in decode, execute and memory, and in the next cycle it sends a one-cycle trap pulse. The pulse carries the cause and a set of saved restart PCs, enough to resume correctly inside a branch's delay slots. In that same cycle it points fetch at a fixed handler address and holds the pipe. Older instructions drain normally. A small state machine with two states sequences this work. RUN is normal flow; its only exit is RUN→TRAP, taken when a faulting instruction is at commit. TRAP lasts one cycle, during which the trap is sent and fetch is ignored; its only exit is TRAP→RUN, taken on the next cycle without a condition.

Top module: `exc_tracker`

## Requirements
- R1: During and right after reset, mem_wr_ok, rf_wr_ok, flush, trap_pulse, fetch_hold and fetch_redirect are all 0.
- R2: Cause codes are 1 page fault, 2 misaligned, 3 protection, 4 undefined opcode, 5 arithmetic, 6 breakpoint. Fetch and memory accept only 1, 2 and 3. Decode accepts only 4 and 6. Execute accepts only 5. A code raised at a stage that does not accept it is ignored, and the instruction commits normally.
- R3: Each bit of mask_en drops one maskable cause at the stage where it is raised: bit0 drops arithmetic (5), bit1 drops misaligned (2), bit2 drops breakpoint (6). Causes 1, 3 and 4 are taken whatever mask_en holds.
- R4: A fault raised on an instruction stays with it through the later stages. If one instruction is raised at more than one stage, the cause from the earliest stage is kept.
- R5: mem_wr_ok is high in the cycle a valid, fault-free instruction sits in the memory stage. rf_wr_ok is high in the cycle after that.
- R6: When several stages raise faults in one cycle, the fault of the deepest (oldest) instruction is taken. A younger instruction raised earlier in time still loses to an older one.
- R7: flush is high in exactly the one cycle that a faulting instruction is at commit. In that cycle mem_wr_ok is 0. Neither that instruction nor any younger one in flight ever asserts mem_wr_ok or rf_wr_ok.
- R8: One cycle after flush, trap_pulse is high for one cycle together with trap_cause, fetch_redirect, fetch_hold, and redirect_pc equal to HANDLER_VEC. A fetch offered in that cycle is discarded.
- R9: Slot j of trap_pcs (bits j*PC_W upward) holds the PC of the instruction j places younger than the faulting one. For breakpoint (6), which resumes after the instruction, each slot holds the PC one place younger again.
- R10: In the cycle after the trap pulse, fetches are accepted again and flow normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | An instruction is in fetch this cycle |
| fetch_pc | input | PC_W | PC of that instruction |
| raise_if | input | 1 | Fault raised on the fetch-stage instruction |
| cause_if | input | 3 | Cause for raise_if |
| raise_id | input | 1 | Fault raised on the decode-stage instruction |
| cause_id | input | 3 | Cause for raise_id |
| raise_ex | input | 1 | Fault raised on the execute-stage instruction |
| cause_ex | input | 3 | Cause for raise_ex |
| raise_mem | input | 1 | Fault raised on the memory-stage instruction |
| cause_mem | input | 3 | Cause for raise_mem |
| mask_en | input | 3 | Drop enables for maskable causes |
| mem_wr_ok | output | 1 | The memory-stage instruction may write memory |
| rf_wr_ok | output | 1 | The write-back instruction may write the register file |
| flush | output | 1 | Kill younger instructions this cycle |
| trap_pulse | output | 1 | One-cycle trap strobe |
| trap_cause | output | 3 | Cause of the taken fault |
| trap_pcs | output | NSAVE*PC_W | Saved restart PCs |
| fetch_redirect | output | 1 | Point fetch at redirect_pc |
| redirect_pc | output | PC_W | Handler address |
| fetch_hold | output | 1 | The pipeline is held this cycle |

## Verification
The bench builds the block with PC_W = 32, NSAVE = 3 and HANDLER_VEC = 0x80. Three slots let the breakpoint shift reach the instruction still in fetch, so every restart source the block can read is used. The bench raises faults at all four stages in one cycle, raises a younger instruction's fault earlier than an older one's, tries masked, unmasked and illegal causes, and raises one instruction twice. It also offers a fetch during the trap cycle to show that the fetch is discarded and that flow resumes afterwards.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam logic [2:0] C_NONE  = 3'd0;
    localparam logic [2:0] C_PGFLT = 3'd1;
    localparam logic [2:0] C_MISAL = 3'd2;
    localparam logic [2:0] C_PROT  = 3'd3;
    localparam logic [2:0] C_UNDEF = 3'd4;
    localparam logic [2:0] C_ARITH = 3'd5;
    localparam logic [2:0] C_BRK   = 3'd6;

    typedef enum logic [1:0] {ST_IF, ST_ID, ST_EX, ST_MEM} stage_e;

    typedef struct packed {
        logic       valid;
        logic       exc;
        logic [2:0] cause;
    } exc_info_t;

    // Legal for the stage and not dropped by its mask bit.
    function automatic logic cause_ok(stage_e s, logic [2:0] c, logic [2:0] m);
        logic legal;
        logic masked;
        unique case (s)
            ST_IF, ST_MEM: legal = (c == C_PGFLT) || (c == C_MISAL) || (c == C_PROT);
            ST_ID:         legal = (c == C_UNDEF) || (c == C_BRK);
            ST_EX:         legal = (c == C_ARITH);
        endcase
        masked = ((c == C_ARITH) && m[0]) || ((c == C_MISAL) && m[1]) ||
                 ((c == C_BRK) && m[2]);
        return legal && !masked;
    endfunction

    // First fault on an instruction is kept.
    function automatic exc_info_t merge(exc_info_t i, stage_e s, logic r,
                                        logic [2:0] c, logic [2:0] m);
        exc_info_t o;
        o = i;
        if (i.valid && !i.exc && r && cause_ok(s, c, m)) begin
            o.exc   = 1'b1;
            o.cause = c;
        end
        return o;
    endfunction

endpackage

// File: rtl/exc_stage.sv
module exc_stage
    import exc_pkg::*;
#(
    parameter int     PC_W  = 32,
    parameter stage_e STAGE = ST_ID
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kill,
    input  exc_info_t       d_info,
    input  logic [PC_W-1:0] d_pc,
    input  logic            raise_i,
    input  logic [2:0]      cause_i,
    input  logic [2:0]      mask_i,
    output logic [PC_W-1:0] q_pc,
    output exc_info_t       eff_o
);

    exc_info_t q_info;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_info <= '0;
            q_pc   <= '0;
        end else if (kill) begin
            q_info <= '0;
            q_pc   <= d_pc;
        end else begin
            q_info <= d_info;
            q_pc   <= d_pc;
        end
    end

    always_comb eff_o = merge(q_info, STAGE, raise_i, cause_i, mask_i);

endmodule

// File: rtl/exc_commit.sv
module exc_commit
    import exc_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter int              NSAVE       = 3,
    parameter logic [PC_W-1:0] HANDLER_VEC = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  exc_info_t                  mem_info,
    input  logic [3:0][PC_W-1:0]       cand,
    output logic                       mem_wr_ok,
    output logic                       rf_wr_ok,
    output logic                       flush,
    output logic                       trap_pulse,
    output logic [2:0]                 trap_cause,
    output logic [NSAVE*PC_W-1:0]      trap_pcs,
    output logic                       fetch_redirect,
    output logic [PC_W-1:0]            redirect_pc,
    output logic                       fetch_hold
);

    typedef enum logic {S_RUN, S_TRAP} state_e;

    state_e state_q, state_d;
    logic   detect;
    logic   wb_q;
    logic   brk;
    logic [2:0] cause_q;
    logic [NSAVE-1:0][PC_W-1:0] save_q;

    assign detect = (state_q == S_RUN) && mem_info.valid && mem_info.exc;
    assign brk    = (mem_info.cause == C_BRK);

    always_comb begin
        unique case (state_q)
            S_RUN:  state_d = detect ? S_TRAP : S_RUN;
            S_TRAP: state_d = S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RUN;
            wb_q    <= 1'b0;
            cause_q <= C_NONE;
        end else begin
            state_q <= state_d;
            wb_q    <= mem_wr_ok;
            if (detect) cause_q <= mem_info.cause;
        end
    end

    for (genvar g = 0; g < NSAVE; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      save_q[g] <= '0;
            else if (detect) save_q[g] <= brk ? cand[g+1] : cand[g];
        end
        assign trap_pcs[g*PC_W +: PC_W] = save_q[g];
    end

    always_comb begin
        mem_wr_ok      = 1'b0;
        flush          = 1'b0;
        trap_pulse     = 1'b0;
        fetch_redirect = 1'b0;
        fetch_hold     = 1'b0;
        redirect_pc    = '0;
        unique case (state_q)
            S_RUN: begin
                mem_wr_ok = mem_info.valid && !mem_info.exc;
                flush     = detect;
            end
            S_TRAP: begin
                trap_pulse     = 1'b1;
                fetch_redirect = 1'b1;
                fetch_hold     = 1'b1;
                redirect_pc    = HANDLER_VEC;
            end
        endcase
    end

    assign rf_wr_ok   = wb_q;
    assign trap_cause = cause_q;

endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
    import exc_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter int              NSAVE       = 3,
    parameter logic [PC_W-1:0] HANDLER_VEC = 32'h0000_0080
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch_valid,
    input  logic [PC_W-1:0]       fetch_pc,
    input  logic                  raise_if,
    input  logic [2:0]            cause_if,
    input  logic                  raise_id,
    input  logic [2:0]            cause_id,
    input  logic                  raise_ex,
    input  logic [2:0]            cause_ex,
    input  logic                  raise_mem,
    input  logic [2:0]            cause_mem,
    input  logic [2:0]            mask_en,
    output logic                  mem_wr_ok,
    output logic                  rf_wr_ok,
    output logic                  flush,
    output logic                  trap_pulse,
    output logic [2:0]            trap_cause,
    output logic [NSAVE*PC_W-1:0] trap_pcs,
    output logic                  fetch_redirect,
    output logic [PC_W-1:0]       redirect_pc,
    output logic                  fetch_hold
);

    localparam int NSTG = 4;

    logic [NSTG-1:0]            raise_v;
    logic [NSTG-1:0][2:0]       cause_v;
    exc_info_t [NSTG-1:0]       eff;
    logic [NSTG-1:0][PC_W-1:0]  pc;
    logic [NSTG-1:0][PC_W-1:0]  cand;
    exc_info_t                  if_info;
    logic                       kill;

    assign raise_v = {raise_mem, raise_ex, raise_id, raise_if};
    assign cause_v = {cause_mem, cause_ex, cause_id, cause_if};
    assign kill    = flush || fetch_hold;

    assign if_info = '{valid: fetch_valid, exc: 1'b0, cause: C_NONE};
    assign eff[0]  = merge(if_info, ST_IF, raise_v[0], cause_v[0], mask_en);
    assign pc[0]   = fetch_pc;

    for (genvar g = 1; g < NSTG; g++) begin : g_stg
        exc_stage #(.PC_W(PC_W), .STAGE(stage_e'(g))) u_stg (
            .clk     (clk),
            .rst_n   (rst_n),
            .kill    (kill),
            .d_info  (eff[g-1]),
            .d_pc    (pc[g-1]),
            .raise_i (raise_v[g]),
            .cause_i (cause_v[g]),
            .mask_i  (mask_en),
            .q_pc    (pc[g]),
            .eff_o   (eff[g])
        );
    end

    for (genvar j = 0; j < NSTG; j++) begin : g_cand
        assign cand[j] = pc[NSTG-1-j];
    end

    exc_commit #(.PC_W(PC_W), .NSAVE(NSAVE), .HANDLER_VEC(HANDLER_VEC)) u_commit (
        .clk            (clk),
        .rst_n          (rst_n),
        .mem_info       (eff[NSTG-1]),
        .cand           (cand),
        .mem_wr_ok      (mem_wr_ok),
        .rf_wr_ok       (rf_wr_ok),
        .flush          (flush),
        .trap_pulse     (trap_pulse),
        .trap_cause     (trap_cause),
        .trap_pcs       (trap_pcs),
        .fetch_redirect (fetch_redirect),
        .redirect_pc    (redirect_pc),
        .fetch_hold     (fetch_hold)
    );

endmodule

// File: rtl/exc_tracker_chk.sv
module exc_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_wr_ok,
    input logic rf_wr_ok,
    input logic flush,
    input logic trap_pulse,
    input logic fetch_redirect,
    input logic fetch_hold
);

    a_r8_flush_then_trap: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> trap_pulse);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |=> !trap_pulse);

    a_r8_trap_from_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_pulse) |-> $past(flush));

    a_r8_hold_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (fetch_hold && fetch_redirect));

    a_r7_flush_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !mem_wr_ok);

    a_r7_no_write_in_trap: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (!mem_wr_ok && !flush));

    a_r5_rf_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_ok |-> $past(mem_wr_ok));

endmodule

bind exc_tracker exc_tracker_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mem_wr_ok      (mem_wr_ok),
    .rf_wr_ok       (rf_wr_ok),
    .flush          (flush),
    .trap_pulse     (trap_pulse),
    .fetch_redirect (fetch_redirect),
    .fetch_hold     (fetch_hold)
);

// File: tb/exc_tracker_tb_top.sv
`timescale 1ns/1ps
module exc_tracker_tb_top;

    localparam int          PC_W  = 32;
    localparam int          NSAVE = 3;
    localparam logic [31:0] VEC   = 32'h0000_0080;
    localparam int          NONE  = -100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_valid = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic raise_if = 1'b0, raise_id = 1'b0, raise_ex = 1'b0, raise_mem = 1'b0;
    logic [2:0] cause_if = '0, cause_id = '0, cause_ex = '0, cause_mem = '0;
    logic [2:0] mask_en = '0;
    logic mem_wr_ok, rf_wr_ok, flush, trap_pulse, fetch_redirect, fetch_hold;
    logic [2:0] trap_cause;
    logic [NSAVE*PC_W-1:0] trap_pcs;
    logic [PC_W-1:0] redirect_pc;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int                    at;
        logic [2:0]            cause;
        logic [NSAVE*PC_W-1:0] pcs;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    exc_tracker #(.PC_W(PC_W), .NSAVE(NSAVE), .HANDLER_VEC(VEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .raise_if(raise_if), .cause_if(cause_if), .raise_id(raise_id), .cause_id(cause_id),
        .raise_ex(raise_ex), .cause_ex(cause_ex), .raise_mem(raise_mem), .cause_mem(cause_mem),
        .mask_en(mask_en), .mem_wr_ok(mem_wr_ok), .rf_wr_ok(rf_wr_ok), .flush(flush),
        .trap_pulse(trap_pulse), .trap_cause(trap_cause), .trap_pcs(trap_pcs),
        .fetch_redirect(fetch_redirect), .redirect_pc(redirect_pc), .fetch_hold(fetch_hold)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: each trap pulse is compared with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && trap_pulse) begin
            if (sbq.size() == 0) begin
                chk("R8 unexpected trap pulse", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk("R8 trap cycle", cyc, e.at);
                chk("R8 trap cause", trap_cause, e.cause);
                chk("R9 restart pcs", trap_pcs, e.pcs);
            end
        end
    end

    // Driver: instruction t is fetched in window t; spec i raises cause sc at
    // stage ss (0 fetch .. 3 memory) on instruction sk.
    task automatic run_case(input string tag, input int n, input logic [31:0] base,
                            input int sk [4], input int ss [4], input int sc [4],
                            input logic [2:0] msk, input int exp_k,
                            input logic [2:0] exp_c, input int exp_commits);
        int st, nm, nr, nf;
        logic [NSAVE*PC_W-1:0] ep;
        @(negedge clk);
        st = cyc;
        mask_en = msk;
        if (exp_k >= 0) begin
            for (int j = 0; j < NSAVE; j++)
                ep[j*PC_W +: PC_W] = base + 32'(4 * (exp_k + j + ((exp_c == 3'd6) ? 1 : 0)));
            sbq.push_back('{at: st + exp_k + 4, cause: exp_c, pcs: ep});
        end
        nm = 0; nr = 0; nf = 0;
        for (int t = 0; t < n + 6; t++) begin
            if (t > 0) @(negedge clk);
            fetch_valid = (t < n);
            fetch_pc    = base + 32'(4 * t);
            raise_if = 0; raise_id = 0; raise_ex = 0; raise_mem = 0;
            cause_if = 0; cause_id = 0; cause_ex = 0; cause_mem = 0;
            for (int i = 0; i < 4; i++) begin
                if (t - ss[i] == sk[i]) begin
                    case (ss[i])
                        0: begin raise_if  = 1; cause_if  = 3'(sc[i]); end
                        1: begin raise_id  = 1; cause_id  = 3'(sc[i]); end
                        2: begin raise_ex  = 1; cause_ex  = 3'(sc[i]); end
                        default: begin raise_mem = 1; cause_mem = 3'(sc[i]); end
                    endcase
                end
            end
            #3;
            nm += int'(mem_wr_ok);
            nr += int'(rf_wr_ok);
            nf += int'(flush);
            if (exp_k >= 0 && t == exp_k + 3) chk({tag, " R7 flush at commit"}, flush, 1);
            if (exp_k >= 0 && t == exp_k + 4) begin
                chk({tag, " R8 fetch_hold"}, fetch_hold, 1);
                chk({tag, " R8 fetch_redirect"}, fetch_redirect, 1);
                chk({tag, " R8 redirect_pc"}, redirect_pc, VEC);
            end
        end
        fetch_valid = 0;
        chk({tag, " R5 memory write count"}, nm, exp_commits);
        chk({tag, " R5 register write count"}, nr, exp_commits);
        chk({tag, " R7 flush count"}, nf, (exp_k >= 0) ? 1 : 0);
    endtask

    initial begin
        #(8 * 150000);
        chk("watchdog expired", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mem_wr_ok", mem_wr_ok, 0);
        chk("R1 reset trap_pulse", trap_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 post reset rf_wr_ok", rf_wr_ok, 0);
        chk("R1 post reset flush", flush, 0);
        chk("R1 post reset hold", {fetch_hold, fetch_redirect}, 0);

        // R5: no faults, six instructions all commit
        run_case("R5 clean", 6, 32'h1000, '{NONE,NONE,NONE,NONE}, '{0,0,0,0},
                 '{0,0,0,0}, 3'b000, -1, 0, 6);
        // R7 / R9: memory page fault on instruction 2
        run_case("R7 mem fault", 6, 32'h2000, '{2,NONE,NONE,NONE}, '{3,0,0,0},
                 '{1,0,0,0}, 3'b000, 2, 3'd1, 2);
        // R6: four stages raise in one cycle; oldest (protection in memory) wins
        run_case("R6 four at once", 4, 32'h3000, '{0,1,2,3}, '{3,2,1,0},
                 '{3,5,4,1}, 3'b000, 0, 3'd3, 0);
        // R6: younger raised earlier in time still loses
        run_case("R6 younger earlier", 4, 32'h3100, '{1,0,NONE,NONE}, '{0,3,0,0},
                 '{2,1,0,0}, 3'b000, 0, 3'd1, 0);
        // R4: decode fault on instruction 1 is carried to commit
        run_case("R4 carried undef", 5, 32'h4000, '{1,NONE,NONE,NONE}, '{1,0,0,0},
                 '{4,0,0,0}, 3'b000, 1, 3'd4, 1);
        // R4: same instruction raised twice, earliest stage cause kept
        run_case("R4 first kept", 5, 32'h4100, '{1,1,NONE,NONE}, '{0,3,0,0},
                 '{2,3,0,0}, 3'b000, 1, 3'd2, 1);
        // R9: breakpoint resumes at the next instruction
        run_case("R9 breakpoint", 4, 32'h5000, '{0,NONE,NONE,NONE}, '{1,0,0,0},
                 '{6,0,0,0}, 3'b000, 0, 3'd6, 0);
        // R3: arithmetic masked, dropped
        run_case("R3 arith masked", 4, 32'h6000, '{1,NONE,NONE,NONE}, '{2,0,0,0},
                 '{5,0,0,0}, 3'b001, -1, 0, 4);
        // R3: arithmetic unmasked, taken
        run_case("R3 arith taken", 5, 32'h6100, '{1,NONE,NONE,NONE}, '{2,0,0,0},
                 '{5,0,0,0}, 3'b000, 1, 3'd5, 1);
        // R3: all masks set, page fault still taken
        run_case("R3 nonmaskable", 4, 32'h6200, '{0,NONE,NONE,NONE}, '{0,0,0,0},
                 '{1,0,0,0}, 3'b111, 0, 3'd1, 0);
        // R2: causes at stages that do not accept them are ignored
        run_case("R2 illegal stage", 4, 32'h7000, '{0,1,2,NONE}, '{2,0,1,0},
                 '{1,5,5,0}, 3'b000, -1, 0, 4);
        // R8: fetch in the trap cycle is discarded
        run_case("R8 fetch dropped", 5, 32'h8000, '{0,NONE,NONE,NONE}, '{3,0,0,0},
                 '{2,0,0,0}, 3'b000, 0, 3'd2, 0);
        // R10: flow resumes after the trap
        run_case("R10 resume", 3, 32'h9000, '{NONE,NONE,NONE,NONE}, '{0,0,0,0},
                 '{0,0,0,0}, 3'b000, -1, 0, 3);

        chk("R8 all expected traps seen", sbq.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule